// File: doc/BRIEF.md
# Pulse-Width Serial Symbol Transmitter

This block drives one wire of a two-level serial bus. Every symbol it sends is a pair of timed phases: the line is first held at the active level, then released to the idle level while the block still drives it. Symbols differ only in how long each of their two phases lasts. A start symbol has a long active phase. A data one has a short active phase and a long idle phase. A data zero has a long active phase and a short idle phase. Both data symbols take the same total time.

A client sends one request over a valid/ready handshake. The request is a start symbol, a single data one, a single data zero, or a whole byte. A byte is sent as eight data symbols, most significant bit first, followed by a parity symbol. There is no gap between these symbols. The output enable is high only while symbols are on the wire. Phase lengths are counted in ticks of a prescaled clock. All tick counts are fixed at elaboration from the clock frequency and the prescale divider.

Top module: `pulse_sym_tx`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, `req_ready` is 1, `bus_oe` is 0 and `bus_level` is 0.
- R2: A start request (`req_kind` = 2'b00) drives the active phase for round(166 us / tick) ticks and then the idle phase for round(19 us / tick) ticks. With the default parameters this is 2656 cycles high and then 304 cycles low.
- R3: A data-one request (`req_kind` = 2'b01) drives the active phase for round(20.5 us / tick) ticks and then the idle phase for round(19 us / tick) ticks. With the defaults this is 328 cycles high and then 304 cycles low.
- R4: A data-zero request (`req_kind` = 2'b10) drives the active phase for round(34 us / tick) ticks and then the idle phase for round(5.5 us / tick) ticks. With the defaults this is 544 cycles high and then 88 cycles low.
- R5: One tick lasts TICK_DIV clock cycles. Each phase lasts exactly its tick count times TICK_DIV cycles. Tick counts are computed at elaboration from CLK_HZ and TICK_DIV, rounded to the nearest tick.
- R6: A data-one symbol and a data-zero symbol each span the nominal bit time of 39.5 us (632 cycles with the defaults).
- R7: A byte request (`req_kind` = 2'b11) sends `req_data[7]` first and `req_data[0]` last, each bit as a data symbol. A ninth symbol follows. It is a data one when `req_data` has an odd number of ones, and a data zero otherwise. `bus_oe` stays high across all nine symbols.
- R8: `bus_level` is 1 only during an active phase. `bus_oe` is 1 only while a phase is being driven, and is 0 otherwise.
- R9: `req_ready` is low from the cycle after a handshake until one cycle after the last idle phase ends. `req_valid` and `req_kind` presented while `req_ready` is low are ignored and do not change the waveform.
- R10: The first active phase starts in the cycle right after the edge on which `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_kind | input | 2 | 00 start, 01 data one, 10 data zero, 11 byte |
| req_data | input | 8 | Byte value for a byte request |
| bus_level | output | 1 | Line level: 1 active phase, 0 idle phase |
| bus_oe | output | 1 | Line driver enable |

## Verification
A wrong tick count or a stuck prescaler appears as an active or idle run of the wrong length. It is visible at the first falling edge of `bus_level` or `bus_oe` after the handshake, at most 2656 cycles in. A wrong byte shift or parity value appears as a data symbol of the wrong kind at that bit position, so it is caught within one bit time. A sequencer that stops early, runs late or accepts a request while busy breaks the one-cycle gap before `req_ready` rises, or changes the measured runs. Random bytes and random requests presented while busy exercise these paths together with the directed values 0x00, 0xFF, 0x80 and 0xA5.

// File: rtl/pst_pkg.sv
// Package: shared request codes, symbol kinds and the tick arithmetic.
// Assumes durations are given in whole nanoseconds.
package pst_pkg;

    typedef enum logic [1:0] {
        KIND_START = 2'b00,
        KIND_ONE   = 2'b01,
        KIND_ZERO  = 2'b10,
        KIND_BYTE  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        SYM_START = 2'b00,
        SYM_ONE   = 2'b01,
        SYM_ZERO  = 2'b10
    } sym_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ACTIVE = 2'b01,
        ST_RELEASE = 2'b10,
        ST_GAP    = 2'b11
    } state_e;

    localparam longint unsigned NS_START_ACT = 166_000;
    localparam longint unsigned NS_START_IDL = 19_000;
    localparam longint unsigned NS_ONE_ACT   = 20_500;
    localparam longint unsigned NS_ONE_IDL   = 19_000;
    localparam longint unsigned NS_ZERO_ACT  = 34_000;
    localparam longint unsigned NS_ZERO_IDL  = 5_500;

    // Convert a duration into ticks of (div / hz) seconds, rounded to nearest.
    function automatic int unsigned ticks_of(longint unsigned ns,
                                             longint unsigned hz,
                                             longint unsigned div);
        longint unsigned den;
        den = div * 64'd1_000_000_000;
        return int'((ns * hz + den / 2) / den);
    endfunction

endpackage

// File: rtl/pst_prescaler.sv
// Module: pst_prescaler
// Emits a one-cycle tick every DIV clock cycles. 'clear' restarts the count,
// so that the first tick after a clear arrives DIV cycles later.
// Assumes DIV >= 1.
module pst_prescaler #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Divider counter: wraps on tick and restarts on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PW'(1);
        end
    end
endmodule

// File: rtl/pst_phase_timer.sv
// Module: pst_phase_timer
// Counts ticks within one phase. 'done' pulses on the last cycle of the
// phase, that is on the tick that completes 'len' ticks.
// Assumes len >= 1 and that it is stable while the phase runs.
module pst_phase_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt;

    assign done = tick && (cnt == len - CW'(1));

    // Tick counter within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/pst_byte_shifter.sv
// Module: pst_byte_shifter
// Holds a byte plus its parity bit and hands them out most significant
// first. 'first_bit' is the bit to send right after a load. 'next_bit' is
// the bit that becomes current on 'advance'. 'last' marks the parity bit.
// Assumes advance is never raised when last is set.
module pst_byte_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] data,
    input  logic          advance,
    output logic          first_bit,
    output logic          next_bit,
    output logic          last
);
    localparam int SW = DW + 1;
    localparam int RW = $clog2(SW + 1);

    logic [SW-1:0] sh;
    logic [RW-1:0] remain;

    assign first_bit = data[DW-1];
    assign next_bit  = sh[SW-2];
    assign last      = (remain == RW'(1));

    // Shift register with the parity bit appended below the data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            remain <= '0;
        end else if (load) begin
            sh     <= {data, ^data};
            remain <= RW'(SW);
        end else if (advance) begin
            sh     <= {sh[SW-2:0], 1'b0};
            remain <= remain - RW'(1);
        end
    end
endmodule

// File: rtl/pulse_sym_tx.sv
// Module: pulse_sym_tx (top)
// Accepts one symbol or byte request per handshake and drives the wire as
// timed active/idle phase pairs. Tick counts come from CLK_HZ and TICK_DIV.
// Assumes req_data and req_kind are only sampled on the accepting edge.
module pulse_sym_tx #(
    parameter int CLK_HZ   = 16_000_000,
    parameter int TICK_DIV = 2,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_data,
    output logic              bus_level,
    output logic              bus_oe
);
    import pst_pkg::*;

    localparam int unsigned T_START_ACT = ticks_of(NS_START_ACT, CLK_HZ, TICK_DIV);
    localparam int unsigned T_START_IDL = ticks_of(NS_START_IDL, CLK_HZ, TICK_DIV);
    localparam int unsigned T_ONE_ACT   = ticks_of(NS_ONE_ACT,   CLK_HZ, TICK_DIV);
    localparam int unsigned T_ONE_IDL   = ticks_of(NS_ONE_IDL,   CLK_HZ, TICK_DIV);
    localparam int unsigned T_ZERO_ACT  = ticks_of(NS_ZERO_ACT,  CLK_HZ, TICK_DIV);
    localparam int unsigned T_ZERO_IDL  = ticks_of(NS_ZERO_IDL,  CLK_HZ, TICK_DIV);
    localparam int unsigned T_MAX       = T_START_ACT;
    localparam int CW = $clog2(T_MAX + 1);

    state_e state;
    sym_e   sym;
    logic   byte_mode;

    logic accept, tick, phase_done, clear;
    logic load_byte, advance;
    logic first_bit, next_bit, last_bit;
    logic [CW-1:0] act_len, idl_len, phase_len;

    assign accept    = req_valid && req_ready;
    assign clear     = accept || phase_done;
    assign load_byte = accept && (kind_e'(req_kind) == KIND_BYTE);
    assign advance   = (state == ST_RELEASE) && phase_done && byte_mode && !last_bit;

    assign req_ready = (state == ST_IDLE);
    assign bus_level = (state == ST_ACTIVE);
    assign bus_oe    = (state == ST_ACTIVE) || (state == ST_RELEASE);

    // Pick the tick counts of the symbol currently on the wire.
    always_comb begin
        case (sym)
            SYM_START: begin
                act_len = CW'(T_START_ACT);
                idl_len = CW'(T_START_IDL);
            end
            SYM_ONE: begin
                act_len = CW'(T_ONE_ACT);
                idl_len = CW'(T_ONE_IDL);
            end
            default: begin
                act_len = CW'(T_ZERO_ACT);
                idl_len = CW'(T_ZERO_IDL);
            end
        endcase
        phase_len = (state == ST_ACTIVE) ? act_len : idl_len;
    end

    pst_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .tick  (tick)
    );

    pst_phase_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .tick  (tick),
        .len   (phase_len),
        .done  (phase_done)
    );

    pst_byte_shifter #(.DW(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_byte),
        .data      (req_data),
        .advance   (advance),
        .first_bit (first_bit),
        .next_bit  (next_bit),
        .last      (last_bit)
    );

    // Sequencer: runs the phase pairs and chains the symbols of a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sym       <= SYM_START;
            byte_mode <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_ACTIVE;
                        case (kind_e'(req_kind))
                            KIND_START: begin sym <= SYM_START; byte_mode <= 1'b0; end
                            KIND_ONE:   begin sym <= SYM_ONE;   byte_mode <= 1'b0; end
                            KIND_ZERO:  begin sym <= SYM_ZERO;  byte_mode <= 1'b0; end
                            default: begin
                                sym       <= first_bit ? SYM_ONE : SYM_ZERO;
                                byte_mode <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACTIVE: begin
                    if (phase_done) state <= ST_RELEASE;
                end
                ST_RELEASE: begin
                    if (phase_done) begin
                        if (advance) begin
                            state <= ST_ACTIVE;
                            sym   <= next_bit ? SYM_ONE : SYM_ZERO;
                        end else begin
                            state <= ST_GAP;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/pulse_sym_tx_chk.sv
// Module: pulse_sym_tx_chk
// Port-level checker bound to pulse_sym_tx. Run lengths are measured with
// counters, so that no long $past window is needed.
module pulse_sym_tx_chk #(
    parameter int CLK_HZ   = 16_000_000,
    parameter int TICK_DIV = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_kind,
    input logic       bus_level,
    input logic       bus_oe
);
    import pst_pkg::*;

    localparam int unsigned C_SA = ticks_of(NS_START_ACT, CLK_HZ, TICK_DIV) * TICK_DIV;
    localparam int unsigned C_SI = ticks_of(NS_START_IDL, CLK_HZ, TICK_DIV) * TICK_DIV;
    localparam int unsigned C_1A = ticks_of(NS_ONE_ACT,   CLK_HZ, TICK_DIV) * TICK_DIV;
    localparam int unsigned C_1I = ticks_of(NS_ONE_IDL,   CLK_HZ, TICK_DIV) * TICK_DIV;
    localparam int unsigned C_0A = ticks_of(NS_ZERO_ACT,  CLK_HZ, TICK_DIV) * TICK_DIV;
    localparam int unsigned C_0I = ticks_of(NS_ZERO_IDL,  CLK_HZ, TICK_DIV) * TICK_DIV;

    int unsigned hi_run, lo_run;

    // Length of the current high run and of the current driven-low run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= 0;
            lo_run <= 0;
        end else begin
            hi_run <= bus_level ? hi_run + 1 : 0;
            lo_run <= (bus_oe && !bus_level) ? lo_run + 1 : 0;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !bus_oe && !bus_level));

    assert_active_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_level) |-> (hi_run == C_SA || hi_run == C_1A || hi_run == C_0A));

    assert_idle_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($rose(bus_level) && lo_run != 0) || $fell(bus_oe))
            |-> (lo_run == C_SI || lo_run == C_1I || lo_run == C_0I));

    assert_level_needs_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_level |-> bus_oe);

    assert_ready_not_driving_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_oe);

    assert_gap_then_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> (!req_ready ##1 req_ready));

    assert_first_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_oe && bus_level && !req_ready));

    assert_kind_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> !$isunknown(req_kind));
endmodule

bind pulse_sym_tx pulse_sym_tx_chk #(
    .CLK_HZ   (CLK_HZ),
    .TICK_DIV (TICK_DIV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .bus_level (bus_level),
    .bus_oe    (bus_oe)
);

// File: tb/sim_pulse_sym_tx.sv
// Bench for pulse_sym_tx: directed symbols and bytes plus seeded random
// requests. Every run of the waveform is measured against values computed
// here from the requirements.
module sim_pulse_sym_tx;
    localparam int CLK_PERIOD = 10;
    localparam longint unsigned HZ  = 16_000_000;
    localparam longint unsigned DIV = 2;
    localparam int WATCHDOG = 190_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic [7:0] req_data = 8'h00;
    logic       req_ready, bus_level, bus_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pulse_sym_tx u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_data  (req_data),
        .bus_level (bus_level),
        .bus_oe    (bus_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Cycles of one phase: nearest whole tick, times the divider (R5).
    function automatic int cyc_of(longint unsigned ns);
        longint unsigned den;
        den = DIV * 64'd1_000_000_000;
        return int'(((ns * HZ + den / 2) / den) * DIV);
    endfunction

    // sym: 0 start, 1 data one, 2 data zero.
    function automatic int act_cyc(int sym);
        return (sym == 0) ? cyc_of(166_000) : (sym == 1) ? cyc_of(20_500) : cyc_of(34_000);
    endfunction

    function automatic int idl_cyc(int sym);
        return (sym == 0) ? cyc_of(19_000) : (sym == 1) ? cyc_of(19_000) : cyc_of(5_500);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Measure the high run and the driven low run of one symbol.
    task automatic measure(input int sym, input string req);
        int n;
        n = 0;
        while (bus_oe && bus_level && n < 5000) begin n++; @(negedge clk); end
        check(n == act_cyc(sym), {req, " active"}, n, act_cyc(sym));
        n = 0;
        while (bus_oe && !bus_level && n < 5000) begin n++; @(negedge clk); end
        check(n == idl_cyc(sym), {req, " idle"}, n, idl_cyc(sym));
    endtask

    // Issue one request, put noise on the inputs while busy, check the waveform.
    task automatic send(input logic [1:0] kind, input logic [7:0] data);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_data  = data;
        @(negedge clk);
        // R9: requests while busy must be ignored.
        req_valid = 1'($urandom);
        req_kind  = 2'($urandom);
        req_data  = 8'($urandom);
        // R10: the active phase is already on at the first sample.
        check(bus_oe && bus_level, "R10 first phase", int'(bus_level), 1);
        if (kind == 2'b00)      measure(0, "R2 start");
        else if (kind == 2'b01) measure(1, "R3 one");
        else if (kind == 2'b10) measure(2, "R4 zero");
        else begin
            for (int i = 7; i >= 0; i--) measure(data[i] ? 1 : 2, "R7 byte bit");
            measure((^data) ? 1 : 2, "R7 parity");
        end
        check(!bus_oe && !req_ready, "R9 gap cycle", int'(req_ready), 0);
        req_valid = 1'b0;
        @(negedge clk);
        check(req_ready && !bus_oe, "R9 ready back", int'(req_ready), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL R9 watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        check(req_ready && !bus_oe && !bus_level, "R1 in reset", int'(bus_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !bus_oe && !bus_level, "R1 after reset", int'(req_ready), 1);

        // R2, R3, R4, R5: literal defaults against bench arithmetic.
        check(act_cyc(0) == 2656 && idl_cyc(0) == 304, "R5 start cycles", act_cyc(0), 2656);
        check(act_cyc(2) == 544 && idl_cyc(2) == 88, "R5 zero cycles", act_cyc(2), 544);
        // R6: both data symbols span 39.5 us.
        check(act_cyc(1) + idl_cyc(1) == 632, "R6 one length", act_cyc(1) + idl_cyc(1), 632);
        check(act_cyc(2) + idl_cyc(2) == 632, "R6 zero length", act_cyc(2) + idl_cyc(2), 632);

        send(2'b00, 8'h00);
        send(2'b01, 8'h00);
        send(2'b10, 8'hFF);
        send(2'b11, 8'h00);
        send(2'b11, 8'hFF);
        send(2'b11, 8'h80);
        send(2'b11, 8'hA5);

        for (int k = 0; k < 10; k++) begin
            logic [1:0] kd;
            logic [7:0] dt;
            kd = 2'($urandom);
            dt = 8'($urandom);
            send(kd, dt);
        end

        // R8: stays quiet while no request is presented.
        repeat (20) @(negedge clk);
        check(!bus_oe && !bus_level && req_ready, "R8 quiet", int'(bus_oe), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule